// File: doc/BRIEF.md
# Clock Mask Controller with Mask-Ready Flag

This block holds four clock-mask registers, one per clock domain: CPU, high-speed bus, peripheral bus A and peripheral bus B. Each module of the chip has a bit in every domain it belongs to. A module's clock enable is high only while every one of its bits is 1. New mask values do not reach the enables at once. They pass through a two-stage synchronizer. A mask-ready flag reports when the applied gating agrees with the register contents again. An interrupt can be enabled for the moment the flag comes back.

The module map for each domain is a parameter. The map gives the bits that exist, and so the modules that take part in that domain. Two modules are singled out: the controller itself and the bus bridge in front of it. If software gates either of them off in the registers, the controller stops responding. Later writes are ignored and reads return 0 until reset.

Top module: `clk_mask_ctrl`

## Requirements
- R1: After reset every implemented mask bit is 1, every `mod_en` bit is 1, `mask_ready` is 1, the interrupt enable is 0 and `irq` is 0.
- R2: When a write clears a module's mask bit, that module's `mod_en` bit falls after the second rising edge that follows the write edge. Writing the bit back to 1 raises `mod_en` again with the same lag.
- R3: A module mapped into several domains has `mod_en` high only while its bit is 1 in every domain it is mapped into.
- R4: Every accepted write to a mask register clears `mask_ready` at the write edge, even when the written value equals the stored one.
- R5: `mask_ready` returns to 1 at the third rising edge after the write edge, which is one edge after the new gating reaches `mod_en`. While `mod_en` is changing, `mask_ready` is 0.
- R6: `irq` is high exactly when the interrupt enable (bit 0 at address 5) and `mask_ready` are both 1, so it rises when the flag returns.
- R7: Once the register contents gate off the controller (module `SELF_MOD`) or its bridge (module `BRIDGE_MOD`), further writes are ignored and `rdata` reads 0 until reset.
- R8: A mask bit whose module is not mapped into that domain reads as 0, and writes to it are ignored.
- R9: Address map: 0 = CPU mask, 1 = high-speed bus mask, 2 = peripheral bus A mask, 3 = peripheral bus B mask, 4 = status (bit 0 is `mask_ready`), 5 = interrupt enable (bit 0). Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| mod_en | output | MOD_COUNT | Clock enable per module, after synchronization |
| mask_ready | output | 1 | Applied gating matches the registers |
| irq | output | 1 | Mask-ready interrupt |

## Verification
The bench uses the default parameters: eight modules, with module 1 in the CPU and high-speed bus domains and module 7 in both peripheral domains. The controller is module 3 and its bridge is module 2. With this map, the all-bits-must-be-set rule can be tested from either domain of a shared module. The lock can be reached through the controller's own bit and, in a separate run after reset, through the bridge's bit. Because the map has holes in every domain, writes of all ones show that unmapped bits are discarded.

// File: rtl/clk_mask_ctrl.sv
module clk_mask_ctrl #(
  parameter int MOD_COUNT = 8,
  parameter logic [MOD_COUNT-1:0] CPU_MAP = 8'h03,
  parameter logic [MOD_COUNT-1:0] HSB_MAP = 8'h06,
  parameter logic [MOD_COUNT-1:0] PBA_MAP = 8'hF8,
  parameter logic [MOD_COUNT-1:0] PBB_MAP = 8'h80,
  parameter int SELF_MOD   = 3,
  parameter int BRIDGE_MOD = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [MOD_COUNT-1:0] mod_en,
  output logic                 mask_ready,
  output logic                 irq
);

  localparam logic [3:0][31:0] MAP =
    {32'(PBB_MAP), 32'(PBA_MAP), 32'(HSB_MAP), 32'(CPU_MAP)};

  logic [3:0][31:0] mask_q, sync1_q, sync2_q;
  logic [1:0]       flight_q;
  logic             ready_q, ie_q;
  logic [MOD_COUNT-1:0] reg_en;
  logic             locked, mask_wr, ie_wr;

  function automatic logic [MOD_COUNT-1:0] combine(input logic [3:0][31:0] m);
    logic [MOD_COUNT-1:0] en;
    en = '1;
    for (int i = 0; i < MOD_COUNT; i++)
      for (int d = 0; d < 4; d++)
        if (MAP[d][i] && !m[d][i]) en[i] = 1'b0;
    return en;
  endfunction

  assign reg_en     = combine(mask_q);
  assign mod_en     = combine(sync2_q);
  assign locked     = !reg_en[SELF_MOD] || !reg_en[BRIDGE_MOD];
  assign mask_wr    = wr_en && !locked && !addr[2];
  assign ie_wr      = wr_en && !locked && (addr == 3'd5);
  assign mask_ready = ready_q;
  assign irq        = ready_q && ie_q;

  always_comb begin
    rdata = '0;
    if (!locked) begin
      case (addr)
        3'd0, 3'd1, 3'd2, 3'd3: rdata = mask_q[addr[1:0]];
        3'd4: rdata = {31'b0, ready_q};
        3'd5: rdata = {31'b0, ie_q};
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= MAP;
      sync1_q  <= MAP;
      sync2_q  <= MAP;
      flight_q <= '0;
      ready_q  <= 1'b1;
      ie_q     <= 1'b0;
    end else begin
      if (mask_wr) mask_q[addr[1:0]] <= wdata & MAP[addr[1:0]];
      if (ie_wr) ie_q <= wdata[0];
      sync1_q  <= mask_q;
      sync2_q  <= sync1_q;
      flight_q <= {flight_q[0], mask_wr};
      ready_q  <= !mask_wr && (flight_q == 2'b00) && (sync2_q == mask_q);
    end
  end

  p_write_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !mask_ready);

  p_ready_means_applied_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ready |-> (sync2_q == mask_q));

  p_enable_moves_unready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_en) |-> !mask_ready);

  p_lock_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(mask_q) && $stable(ie_q));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~MAP) == '0);

endmodule

// File: tb/clk_mask_ctrl_bench.sv
module clk_mask_ctrl_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] mod_en;
  logic mask_ready, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  clk_mask_ctrl u_clk_mask_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mod_en(mod_en), .mask_ready(mask_ready), .irq(irq));

  // {addr, wdata, expected readback, expected mod_en}
  localparam int NV = 11;
  localparam logic [74:0] VEC [NV] = '{
    {3'd0, 32'h0000_0001, 32'h01, 8'hFD},
    {3'd0, 32'hFFFF_FFFF, 32'h03, 8'hFF},
    {3'd1, 32'h0000_0004, 32'h04, 8'hFD},
    {3'd1, 32'h0000_0006, 32'h06, 8'hFF},
    {3'd3, 32'h0000_0000, 32'h00, 8'h7F},
    {3'd2, 32'h0000_0078, 32'h78, 8'h7F},
    {3'd3, 32'h0000_0080, 32'h80, 8'h7F},
    {3'd2, 32'h0000_00E8, 32'hE8, 8'hEF},
    {3'd0, 32'h0000_0000, 32'h00, 8'hEC},
    {3'd2, 32'hFFFF_FFF8, 32'hF8, 8'hFC},
    {3'd0, 32'h0000_0003, 32'h03, 8'hFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    #1;
    check("R1 mod_en", 32'(mod_en), 32'hFF);
    check("R1 ready", 32'(mask_ready), 1);
    check("R1 irq", 32'(irq), 0);
    rd(3'd0, r); check("R1 cpu", r, 32'h03);
    rd(3'd1, r); check("R1 hsb", r, 32'h06);
    rd(3'd2, r); check("R1 pba", r, 32'hF8);
    rd(3'd3, r); check("R1 pbb", r, 32'h80);
    rd(3'd5, r); check("R1 ie", r, 0);
    rd(3'd4, r); check("R9 status", r, 1);
    rd(3'd6, r); check("R9 addr6", r, 0);

    // R2 R3 R8 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][74:72], VEC[i][71:40]);
      repeat (3) @(negedge clk);
      #1;
      check("R3 table mod_en", 32'(mod_en), 32'(VEC[i][7:0]));
      check("R5 table ready", 32'(mask_ready), 1);
      rd(VEC[i][74:72], r);
      check("R8 table readback", r, VEC[i][39:8]);
    end

    // R4 R5 unchanged write timing
    wr(3'd0, 32'h3);
    check("R4 cleared", 32'(mask_ready), 0);
    @(negedge clk); check("R5 not yet k1", 32'(mask_ready), 0);
    @(negedge clk); check("R5 not yet k2", 32'(mask_ready), 0);
    @(negedge clk); check("R5 back k3", 32'(mask_ready), 1);

    // R2 lag
    wr(3'd0, 32'h2);
    check("R2 lag0", 32'(mod_en[0]), 1);
    @(negedge clk); check("R2 lag1", 32'(mod_en[0]), 1);
    @(negedge clk); check("R2 off", 32'(mod_en[0]), 0);
    check("R5 ready low at change", 32'(mask_ready), 0);
    wr(3'd0, 32'h3);
    @(negedge clk); check("R2 still off", 32'(mod_en[0]), 0);
    @(negedge clk); check("R2 on", 32'(mod_en[0]), 1);
    @(negedge clk);

    // R6 interrupt
    wr(3'd5, 32'h1);
    check("R6 irq on", 32'(irq), 1);
    wr(3'd3, 32'h0);
    check("R6 irq drops", 32'(irq), 0);
    repeat (2) @(negedge clk);
    check("R6 irq still low", 32'(irq), 0);
    @(negedge clk); check("R6 irq rises", 32'(irq), 1);
    wr(3'd5, 32'h0);
    check("R6 irq disabled", 32'(irq), 0);

    // R7 lock via own bit
    do_reset();
    wr(3'd2, 32'hF0);
    repeat (3) @(negedge clk);
    #1 check("R7 self off", 32'(mod_en), 32'hF7);
    rd(3'd2, r); check("R7 read zero", r, 0);
    wr(3'd0, 32'h0);
    check("R7 ready kept", 32'(mask_ready), 1);
    repeat (4) @(negedge clk);
    #1 check("R7 write ignored", 32'(mod_en), 32'hF7);
    do_reset();
    #1 check("R7 reset unlocks", 32'(mod_en), 32'hFF);
    rd(3'd2, r); check("R7 pba after reset", r, 32'hF8);

    // R7 lock via bridge bit
    wr(3'd1, 32'h2);
    rd(3'd4, r); check("R7 bridge read zero", r, 0);
    wr(3'd5, 32'h1);
    repeat (4) @(negedge clk);
    #1 check("R7 ie ignored", 32'(irq), 0);
    check("R7 bridge gating", 32'(mod_en), 32'hFB);
    do_reset();
    rd(3'd1, r); check("R7 hsb restored", r, 32'h06);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule